// File: doc/BRIEF.md
# DMA Transfer Address and Count Engine

This block holds the per-channel transfer state of a multi-channel DMA controller and advances it on every accepted transfer acknowledge. Each channel keeps a base and a current 16-bit address, a base and a current 16-bit count, an 8-bit page value and two mode flags: word mode and automatic reload. When an acknowledge reaches an unmasked channel, the block registers the 24-bit physical address of that transfer and drives it out one cycle later. In the same clock edge it steps the channel's address up by one and its count down by one.

In byte mode the page supplies physical bits 23:16. In word mode the 16-bit address counter drives physical bits 16:1. Physical bit 0 is then zero and page bit 0 has no effect. The page value never receives a carry from the address counter, so a transfer stays inside a fixed 64K-byte or 128K-byte window. When the count steps past zero, the block flags terminal count. It then either reloads the current values from the base values or masks the channel. A read port returns the current address, current count and mask state of any channel, so software can compute the residue as count plus one.

Top module: `dma_eng`

## Requirements
- R1: After reset every channel is masked (rd_masked_o = 1) and addr_valid_o and tc_o are 0.
- R2: In byte mode (ld_word = 0) the address issued for a transfer is {page[7:0], current_address[15:0]}.
- R3: In word mode (ld_word = 1) the address issued is {page[7:1], current_address[15:0], 1'b0}. Page bit 0 is ignored and addr_o[0] is 0.
- R4: An acknowledge accepted in cycle k gives addr_valid_o = 1 with that transfer's address in cycle k+1. The channel's current address then reads one higher and its count one lower. Acknowledges that are not accepted leave addr_valid_o at 0.
- R5: Stepping the current address from 0xFFFF wraps it to 0x0000 and leaves the page unchanged. The page changes only through a load.
- R6: tc_o is 1 for exactly the one output cycle that belongs to the acknowledge that found the current count at 0x0000. After that acknowledge, without reload, the count reads 0xFFFF, so the residue (count + 1, modulo 2^16) is zero.
- R7: At terminal count with ld_auto = 0, the channel becomes masked. Later acknowledges give no output and change neither address nor count until unmask_valid names the channel.
- R8: At terminal count with ld_auto = 1, the current address and count are reloaded from the base values and the channel stays unmasked.
- R9: An acknowledge to a masked channel is ignored: no output, and the address and count are held.
- R10: A load writes both the base and the current values, plus the page and the modes, and does not change the mask. A load and an acknowledge to the same channel in the same cycle: the load takes effect and the acknowledge is dropped.
- R11: Channels are independent. Stepping one channel leaves every other channel's address, count and mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Load strobe for the channel named by ld_ch |
| ld_ch | input | CHW | Channel to load |
| ld_base_addr | input | AW | Start address, written to the base and current address |
| ld_base_cnt | input | AW | Transfers minus one, written to the base and current count |
| ld_page | input | PW | Page value |
| ld_word | input | 1 | 1 = word channel, 0 = byte channel |
| ld_auto | input | 1 | 1 = reload from the base values at terminal count |
| unmask_valid | input | 1 | Clears the mask of the channel named by unmask_ch |
| unmask_ch | input | CHW | Channel to unmask |
| ack_valid | input | 1 | Transfer acknowledge |
| ack_ch | input | CHW | Channel being acknowledged |
| addr_valid_o | output | 1 | Registered: an accepted transfer's address is on addr_o |
| addr_o | output | PW+AW | Physical address of the transfer |
| tc_o | output | 1 | Terminal count for that transfer |
| rd_ch | input | CHW | Channel whose state the read port shows |
| rd_addr_o | output | AW | Current address of rd_ch |
| rd_cnt_o | output | AW | Current count of rd_ch |
| rd_masked_o | output | 1 | Mask state of rd_ch |

## Verification
The hardest situation to reach is a transfer whose address wraps at 0xFFFF while the count runs out in the same run, with no page carry. A short check can only get there from a carefully chosen start. The stimulus loads a start address two below the wrap and a count of three, so that four acknowledges cross the boundary and then reach terminal count. It then keeps acknowledging the stopped channel to show that the mask holds. A word channel with reload goes through its terminal count twice in a row, and one cycle drives a load and an acknowledge to the same channel together.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

    // What a channel does with its state on a clock edge
    typedef enum logic [1:0] {
        STEP_NONE   = 2'd0,
        STEP_ADV    = 2'd1,
        STEP_RELOAD = 2'd2,
        STEP_HALT   = 2'd3
    } step_kind_e;

    localparam int DEF_NCH = 4;
    localparam int DEF_AW  = 16;
    localparam int DEF_PW  = 8;

endpackage

// File: rtl/dma_eng_addr_map.sv
module dma_eng_addr_map #(
    parameter int AW = 16,
    parameter int PW = 8,
    localparam int PAW = PW + AW
) (
    input  logic [PW-1:0]  page,
    input  logic [AW-1:0]  cur_addr,
    input  logic           word_mode,
    output logic [PAW-1:0] phys
);

    logic [PAW-1:0] byte_phys;
    logic [PAW-1:0] word_phys;

    always_comb begin
        byte_phys = {page, cur_addr};
        word_phys = {page[PW-1:1], cur_addr, 1'b0};
        phys      = word_mode ? word_phys : byte_phys;
    end

endmodule

// File: rtl/dma_eng_chan.sv
module dma_eng_chan
    import dma_eng_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_hit,
    input  logic [AW-1:0] ld_base_addr,
    input  logic [AW-1:0] ld_base_cnt,
    input  logic [PW-1:0] ld_page,
    input  logic          ld_word,
    input  logic          ld_auto,
    input  logic          unmask_hit,
    input  logic          ack_hit,
    output logic          take,
    output logic          tc_now,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] cur_cnt,
    output logic [PW-1:0] page,
    output logic          word_mode,
    output logic          auto_mode,
    output logic          masked
);

    typedef struct packed {
        logic [AW-1:0] base_addr;
        logic [AW-1:0] base_cnt;
        logic [AW-1:0] addr;
        logic [AW-1:0] cnt;
        logic [PW-1:0] page;
        logic          word;
        logic          auto;
        logic          masked;
    } chan_state_t;

    chan_state_t st_d, st_q;
    step_kind_e  kind;

    // Decide the kind of step for this edge
    always_comb begin
        take   = ack_hit && !st_q.masked && !ld_hit;
        tc_now = take && (st_q.cnt == '0);
        if (!take)
            kind = STEP_NONE;
        else if (!tc_now)
            kind = STEP_ADV;
        else if (st_q.auto)
            kind = STEP_RELOAD;
        else
            kind = STEP_HALT;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        if (ld_hit) begin
            st_d.base_addr = ld_base_addr;
            st_d.base_cnt  = ld_base_cnt;
            st_d.addr      = ld_base_addr;
            st_d.cnt       = ld_base_cnt;
            st_d.page      = ld_page;
            st_d.word      = ld_word;
            st_d.auto      = ld_auto;
        end else begin
            case (kind)
                STEP_ADV: begin
                    st_d.addr = st_q.addr + AW'(1);
                    st_d.cnt  = st_q.cnt - AW'(1);
                end
                STEP_RELOAD: begin
                    st_d.addr = st_q.base_addr;
                    st_d.cnt  = st_q.base_cnt;
                end
                STEP_HALT: begin
                    st_d.addr = st_q.addr + AW'(1);
                    st_d.cnt  = st_q.cnt - AW'(1);
                end
                default: ;
            endcase
        end
        if (unmask_hit)
            st_d.masked = 1'b0;
        if (kind == STEP_HALT)
            st_d.masked = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.masked <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cur_addr  = st_q.addr;
        cur_cnt   = st_q.cnt;
        page      = st_q.page;
        word_mode = st_q.word;
        auto_mode = st_q.auto;
        masked    = st_q.masked;
    end

endmodule

// File: rtl/dma_eng.sv
module dma_eng
    import dma_eng_pkg::*;
#(
    parameter int NCH = DEF_NCH,
    parameter int AW  = DEF_AW,
    parameter int PW  = DEF_PW,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int PAW = PW + AW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld_valid,
    input  logic [CHW-1:0] ld_ch,
    input  logic [AW-1:0]  ld_base_addr,
    input  logic [AW-1:0]  ld_base_cnt,
    input  logic [PW-1:0]  ld_page,
    input  logic           ld_word,
    input  logic           ld_auto,
    input  logic           unmask_valid,
    input  logic [CHW-1:0] unmask_ch,
    input  logic           ack_valid,
    input  logic [CHW-1:0] ack_ch,
    output logic           addr_valid_o,
    output logic [PAW-1:0] addr_o,
    output logic           tc_o,
    input  logic [CHW-1:0] rd_ch,
    output logic [AW-1:0]  rd_addr_o,
    output logic [AW-1:0]  rd_cnt_o,
    output logic           rd_masked_o
);

    typedef struct packed {
        logic           valid;
        logic [PAW-1:0] addr;
        logic           tc;
    } out_t;

    logic [NCH-1:0]          take_vec;
    logic [NCH-1:0]          tc_vec;
    logic [NCH-1:0]          mask_vec;
    logic [NCH-1:0]          word_vec;
    logic [NCH-1:0]          auto_vec;
    logic [NCH-1:0][AW-1:0]  addr_arr;
    logic [NCH-1:0][AW-1:0]  cnt_arr;
    logic [NCH-1:0][PW-1:0]  page_arr;
    logic [NCH-1:0][PAW-1:0] phys_arr;

    out_t out_d, out_q;

    for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
        logic ld_hit_g;
        logic unmask_hit_g;
        logic ack_hit_g;

        always_comb begin
            ld_hit_g     = ld_valid && (ld_ch == CHW'(gi));
            unmask_hit_g = unmask_valid && (unmask_ch == CHW'(gi));
            ack_hit_g    = ack_valid && (ack_ch == CHW'(gi));
        end

        dma_eng_chan #(
            .AW (AW),
            .PW (PW)
        ) u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .ld_hit       (ld_hit_g),
            .ld_base_addr (ld_base_addr),
            .ld_base_cnt  (ld_base_cnt),
            .ld_page      (ld_page),
            .ld_word      (ld_word),
            .ld_auto      (ld_auto),
            .unmask_hit   (unmask_hit_g),
            .ack_hit      (ack_hit_g),
            .take         (take_vec[gi]),
            .tc_now       (tc_vec[gi]),
            .cur_addr     (addr_arr[gi]),
            .cur_cnt      (cnt_arr[gi]),
            .page         (page_arr[gi]),
            .word_mode    (word_vec[gi]),
            .auto_mode    (auto_vec[gi]),
            .masked       (mask_vec[gi])
        );

        dma_eng_addr_map #(
            .AW (AW),
            .PW (PW)
        ) u_map (
            .page      (page_arr[gi]),
            .cur_addr  (addr_arr[gi]),
            .word_mode (word_vec[gi]),
            .phys      (phys_arr[gi])
        );
    end

    // Output stage: select the acknowledged channel
    always_comb begin
        out_d = '0;
        for (int i = 0; i < NCH; i++) begin
            if (take_vec[i]) begin
                out_d.valid = 1'b1;
                out_d.addr  = phys_arr[i];
                out_d.tc    = tc_vec[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    always_comb begin
        addr_valid_o = out_q.valid;
        addr_o       = out_q.addr;
        tc_o         = out_q.tc;
    end

    // Read port
    always_comb begin
        rd_addr_o   = '0;
        rd_cnt_o    = '0;
        rd_masked_o = 1'b1;
        for (int i = 0; i < NCH; i++) begin
            if (rd_ch == CHW'(i)) begin
                rd_addr_o   = addr_arr[i];
                rd_cnt_o    = cnt_arr[i];
                rd_masked_o = mask_vec[i];
            end
        end
    end

endmodule

// File: rtl/dma_eng_chk.sv
module dma_eng_chk #(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int PW  = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int PAW = PW + AW
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ack_valid,
    input logic [CHW-1:0]         ack_ch,
    input logic                   ld_valid,
    input logic [CHW-1:0]         ld_ch,
    input logic                   addr_valid_o,
    input logic [PAW-1:0]         addr_o,
    input logic                   tc_o,
    input logic [NCH-1:0]         mask_vec,
    input logic [NCH-1:0]         word_vec,
    input logic [NCH-1:0]         auto_vec,
    input logic [NCH-1:0][AW-1:0] cnt_arr,
    input logic [NCH-1:0][PW-1:0] page_arr
);

    logic ch_ok;
    logic ld_same;
    always_comb begin
        ch_ok   = int'(ack_ch) < NCH;
        ld_same = ld_valid && (ld_ch == ack_ch);
    end

    assert_tc_with_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o |-> addr_valid_o);

    assert_out_needs_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_o |-> $past(ack_valid));

    assert_masked_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ch_ok && mask_vec[ack_ch]) |=> !addr_valid_o);

    assert_halt_masks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ch_ok && !mask_vec[ack_ch] && !ld_same &&
         cnt_arr[ack_ch] == '0 && !auto_vec[ack_ch]) |=> mask_vec[$past(ack_ch)]);

    assert_word_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ch_ok && !mask_vec[ack_ch] && !ld_same && word_vec[ack_ch])
        |=> (addr_valid_o && !addr_o[0]));

    assert_page_no_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> $stable(page_arr));

endmodule

bind dma_eng dma_eng_chk #(
    .NCH (NCH),
    .AW  (AW),
    .PW  (PW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack_valid    (ack_valid),
    .ack_ch       (ack_ch),
    .ld_valid     (ld_valid),
    .ld_ch        (ld_ch),
    .addr_valid_o (addr_valid_o),
    .addr_o       (addr_o),
    .tc_o         (tc_o),
    .mask_vec     (mask_vec),
    .word_vec     (word_vec),
    .auto_vec     (auto_vec),
    .cnt_arr      (cnt_arr),
    .page_arr     (page_arr)
);

// File: tb/dma_eng_tb.sv
`timescale 1ns/1ps
module dma_eng_tb;

    localparam int NCH = 4;
    localparam int AW  = 16;
    localparam int PW  = 8;
    localparam int CHW = 2;
    localparam int PAW = 24;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ld_valid = 1'b0;
    logic [CHW-1:0] ld_ch = '0;
    logic [AW-1:0]  ld_base_addr = '0;
    logic [AW-1:0]  ld_base_cnt = '0;
    logic [PW-1:0]  ld_page = '0;
    logic           ld_word = 1'b0;
    logic           ld_auto = 1'b0;
    logic           unmask_valid = 1'b0;
    logic [CHW-1:0] unmask_ch = '0;
    logic           ack_valid = 1'b0;
    logic [CHW-1:0] ack_ch = '0;
    logic           addr_valid_o;
    logic [PAW-1:0] addr_o;
    logic           tc_o;
    logic [CHW-1:0] rd_ch = '0;
    logic [AW-1:0]  rd_addr_o;
    logic [AW-1:0]  rd_cnt_o;
    logic           rd_masked_o;

    always #4 clk = ~clk;

    dma_eng #(.NCH(NCH), .AW(AW), .PW(PW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_ch(ld_ch), .ld_base_addr(ld_base_addr),
        .ld_base_cnt(ld_base_cnt), .ld_page(ld_page), .ld_word(ld_word),
        .ld_auto(ld_auto), .unmask_valid(unmask_valid), .unmask_ch(unmask_ch),
        .ack_valid(ack_valid), .ack_ch(ack_ch),
        .addr_valid_o(addr_valid_o), .addr_o(addr_o), .tc_o(tc_o),
        .rd_ch(rd_ch), .rd_addr_o(rd_addr_o), .rd_cnt_o(rd_cnt_o),
        .rd_masked_o(rd_masked_o)
    );

    typedef struct {
        bit             v;
        logic [PAW-1:0] pa;
        bit             tc;
        string          tag;
    } exp_t;

    exp_t sbq[$];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference state, kept from the requirements
    logic [AW-1:0] m_base_a [NCH];
    logic [AW-1:0] m_base_c [NCH];
    logic [AW-1:0] m_addr   [NCH];
    logic [AW-1:0] m_cnt    [NCH];
    logic [PW-1:0] m_page   [NCH];
    bit            m_word   [NCH];
    bit            m_auto   [NCH];
    bit            m_mask   [NCH];

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [PAW-1:0] phys(input int ch);
        if (m_word[ch])
            return {m_page[ch][PW-1:1], m_addr[ch], 1'b0};
        return {m_page[ch], m_addr[ch]};
    endfunction

    task automatic do_load(input int ch, input logic [AW-1:0] a, input logic [AW-1:0] c,
                           input logic [PW-1:0] p, input bit w, input bit au);
        @(negedge clk);
        ld_valid = 1'b1; ld_ch = CHW'(ch); ld_base_addr = a; ld_base_cnt = c;
        ld_page = p; ld_word = w; ld_auto = au;
        m_base_a[ch] = a; m_base_c[ch] = c; m_addr[ch] = a; m_cnt[ch] = c;
        m_page[ch] = p; m_word[ch] = w; m_auto[ch] = au;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic do_unmask(input int ch);
        @(negedge clk);
        unmask_valid = 1'b1; unmask_ch = CHW'(ch);
        m_mask[ch] = 1'b0;
        @(negedge clk);
        unmask_valid = 1'b0;
    endtask

    task automatic model_step(input int ch, inout exp_t e);
        if (m_mask[ch]) begin
            e.v = 1'b0; e.pa = '0; e.tc = 1'b0;
        end else begin
            e.v = 1'b1; e.pa = phys(ch); e.tc = (m_cnt[ch] == '0);
            if (e.tc && m_auto[ch]) begin
                m_addr[ch] = m_base_a[ch]; m_cnt[ch] = m_base_c[ch];
            end else begin
                m_addr[ch] = m_addr[ch] + 16'd1; m_cnt[ch] = m_cnt[ch] - 16'd1;
                if (e.tc) m_mask[ch] = 1'b1;
            end
        end
    endtask

    task automatic do_ack(input int ch, input string tag);
        exp_t e;
        @(negedge clk);
        ack_valid = 1'b1; ack_ch = CHW'(ch);
        e.tag = tag;
        model_step(ch, e);
        sbq.push_back(e);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic check_state(input int ch, input string tag);
        repeat (2) @(negedge clk);
        rd_ch = CHW'(ch);
        #1;
        chk(rd_addr_o == m_addr[ch], tag, "rd_addr", rd_addr_o, m_addr[ch]);
        chk(rd_cnt_o == m_cnt[ch], tag, "rd_cnt", rd_cnt_o, m_cnt[ch]);
        chk(rd_masked_o == m_mask[ch], tag, "rd_masked", rd_masked_o, m_mask[ch]);
    endtask

    // Monitor: compare each registered result with the queued expectation
    always @(posedge clk) begin
        #2;
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            chk(addr_valid_o == e.v, e.tag, "addr_valid", addr_valid_o, e.v);
            if (e.v) begin
                chk(addr_o == e.pa, e.tag, "addr", addr_o, e.pa);
                chk(tc_o == e.tc, e.tag, "tc", tc_o, e.tc);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NCH; i++) begin
            m_base_a[i] = '0; m_base_c[i] = '0; m_addr[i] = '0; m_cnt[i] = '0;
            m_page[i] = '0; m_word[i] = 0; m_auto[i] = 0; m_mask[i] = 1;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < NCH; i++) begin
            rd_ch = CHW'(i);
            #1;
            chk(rd_masked_o == 1'b1, "R1", "masked after reset", rd_masked_o, 1);
        end
        chk(addr_valid_o == 1'b0 && tc_o == 1'b0, "R1", "outputs idle", addr_valid_o, 0);

        // R9: ack to a never-unmasked channel
        do_load(2, 16'h1234, 16'd5, 8'h40, 0, 0);
        do_ack(2, "R9");
        check_state(2, "R9");

        // R2, R4, R5, R6, R7: byte channel crossing the 64K wrap
        do_load(0, 16'hFFFE, 16'd3, 8'h12, 0, 0);
        check_state(0, "R10");
        do_unmask(0);
        do_ack(0, "R2");
        check_state(0, "R4");
        do_ack(0, "R2");
        do_ack(0, "R5");
        check_state(0, "R5");
        do_ack(0, "R6");
        check_state(0, "R6");
        chk(rd_cnt_o + 16'd1 == 16'd0, "R6", "residue", rd_cnt_o + 16'd1, 0);
        do_ack(0, "R7");
        do_ack(0, "R7");
        check_state(0, "R7");
        do_unmask(0);
        do_ack(0, "R7");
        check_state(0, "R7");

        // R3, R8: word channel with reload, odd page
        do_load(1, 16'h8000, 16'd1, 8'h35, 1, 1);
        do_unmask(1);
        do_ack(1, "R3");
        do_ack(1, "R3");
        check_state(1, "R8");
        do_ack(1, "R8");
        do_ack(1, "R8");
        check_state(1, "R8");

        // R11: interleave two channels
        do_load(3, 16'h00F0, 16'd10, 8'hA1, 0, 0);
        do_unmask(3);
        for (int k = 0; k < 3; k++) begin
            do_ack(3, "R11");
            do_ack(1, "R11");
        end
        check_state(0, "R11");
        check_state(2, "R11");
        check_state(3, "R11");

        // R10: load and ack on the same channel in one cycle
        begin
            exp_t e;
            @(negedge clk);
            ld_valid = 1'b1; ld_ch = 2'd3; ld_base_addr = 16'h7000; ld_base_cnt = 16'd2;
            ld_page = 8'h05; ld_word = 1'b0; ld_auto = 1'b0;
            ack_valid = 1'b1; ack_ch = 2'd3;
            m_base_a[3] = 16'h7000; m_base_c[3] = 16'd2; m_addr[3] = 16'h7000;
            m_cnt[3] = 16'd2; m_page[3] = 8'h05; m_word[3] = 0; m_auto[3] = 0;
            e.v = 1'b0; e.pa = '0; e.tc = 1'b0; e.tag = "R10";
            sbq.push_back(e);
            @(negedge clk);
            ld_valid = 1'b0; ack_valid = 1'b0;
        end
        check_state(3, "R10");
        do_ack(3, "R10");

        repeat (4) @(negedge clk);
        chk(sbq.size() == 0, "R4", "scoreboard drained", sbq.size(), 0);
        finish_run();
    end

endmodule